// File: doc/BRIEF.md
# Host-to-Core Doorbell Interrupt Controller

This block sits between a host bus and an embedded controller core that share a memory holding command and status blocks. It gives each side a small register port. The host uses its port to take the core out of reset. It also rings a doorbell after it has placed a command in shared memory, and clears the status interrupt that the core raises when it has posted a result. The core uses its port to acknowledge doorbells and to raise status events toward the host.

Doorbell and status are vectors of `NCH` independent channel bits. The register data width equals `NCH`. A core interrupt line is raised while any doorbell bit is pending. A status event is first held in a host-readable status register, and reaches the host interrupt line only through a per-channel enable mask. All outputs come from flip-flops. Reset is synchronous and active high.

Host register map (address: name, access):
- 0: control. Bit 0 set to 1 releases the core; 0 holds it in reset. It reads back the same bit.
- 1: doorbell. Writing a 1 to a bit sets that bit. It reads the pending bits.
- 2: status. Writing a 1 to a bit clears that bit. It reads the pending bits.
- 3: enable mask. Plain read/write.

Core register map:
- 0: doorbell. Writing a 1 to a bit clears that bit. It reads the pending bits.
- 1: status. Writing a 1 to a bit sets that bit. It reads the pending bits.
- 2, 3: unused. They read as zero and ignore writes.

Top module: `hcd_doorbell_top`

## Requirements
- R1: After reset, `core_rst_o` is 1, `core_irq_o` and `host_irq_o` are 0, and every register (doorbell, status, enable mask, control bit 0) reads 0.
- R2: A host write to address 0 sets `core_rst_o` to the inverse of write data bit 0 from the next clock edge on.
- R3: A host write to address 1 sets each doorbell bit whose data bit is 1. Bits written 0 keep their value.
- R4: A core write to address 0 clears each doorbell bit whose data bit is 1. `core_irq_o` is 1 exactly when at least one doorbell bit is set, and it changes at the same edge as the bits.
- R5: When the host sets and the core clears the same doorbell bit in one cycle, the bit ends up set.
- R6: A core write to address 1 sets each status bit whose data bit is 1. A host write to address 2 clears each status bit whose data bit is 1.
- R7: When the core sets and the host clears the same status bit in one cycle, the bit ends up set.
- R8: `host_irq_o` is 1 exactly when some status bit and the same enable-mask bit are both set. It changes at the same edge as those registers.
- R9: While `core_rst_o` is 1, core writes have no effect: no doorbell bit is cleared and no status bit is set.
- R10: Each read port returns, one edge after an address is presented, the register selected by that address as it stood before that edge.
- R11: Core addresses 2 and 3 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | NCH | Host write data |
| host_rdata | output | NCH | Host read data, registered |
| core_we | input | 1 | Core write strobe |
| core_addr | input | 2 | Core register address |
| core_wdata | input | NCH | Core write data |
| core_rdata | output | NCH | Core read data, registered |
| core_rst_o | output | 1 | Holds the embedded core in reset while 1 |
| core_irq_o | output | 1 | Doorbell interrupt to the core |
| host_irq_o | output | 1 | Status interrupt to the host bus |

## Verification
The bench builds the block with the default `NCH` of 8. That width puts eight independent channel bits in every doorbell, status and mask register. Random multi-bit write data therefore mixes set, clear and collision cases across channels in a single cycle, and a bit leaking into its neighbour would show up. Random control writes keep moving the core in and out of reset, so the windows in which core writes must be ignored keep recurring amid normal traffic.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int REG_AW = 2;

  // host side register addresses
  localparam logic [REG_AW-1:0] H_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] H_DBELL = 2'd1;
  localparam logic [REG_AW-1:0] H_STAT  = 2'd2;
  localparam logic [REG_AW-1:0] H_IEN   = 2'd3;

  // core side register addresses (2 and 3 unused)
  localparam logic [REG_AW-1:0] C_DBELL = 2'd0;
  localparam logic [REG_AW-1:0] C_STAT  = 2'd1;
endpackage

// File: rtl/hcd_event_bits.sv
// Vector of independent event bits with set and clear requests.
// SET_WINS picks the collision rule per bit.
module hcd_event_bits #(
  parameter int NCH      = 8,
  parameter bit SET_WINS = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] bits_q,
  output logic [NCH-1:0] bits_nxt
);
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    if (SET_WINS) begin : g_set_wins
      assign bits_nxt[i] = set_i[i] | (bits_q[i] & ~clr_i[i]);
    end else begin : g_clr_wins
      assign bits_nxt[i] = ~clr_i[i] & (bits_q[i] | set_i[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_nxt;
  end
endmodule

// File: rtl/hcd_ctrl_reg.sv
// Host-owned control: core reset hold and interrupt enable mask.
module hcd_ctrl_reg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we_ctrl,
  input  logic           we_ien,
  input  logic [NCH-1:0] wdata,
  output logic           hold_q,
  output logic [NCH-1:0] ien_q,
  output logic [NCH-1:0] ien_nxt
);
  assign ien_nxt = we_ien ? wdata : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      ien_q  <= '0;
    end else begin
      if (we_ctrl) hold_q <= ~wdata[0];
      ien_q <= ien_nxt;
    end
  end
endmodule

// File: rtl/hcd_doorbell_top.sv
module hcd_doorbell_top
  import hcd_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [NCH-1:0]    host_wdata,
  output logic [NCH-1:0]    host_rdata,
  input  logic              core_we,
  input  logic [REG_AW-1:0] core_addr,
  input  logic [NCH-1:0]    core_wdata,
  output logic [NCH-1:0]    core_rdata,
  output logic              core_rst_o,
  output logic              core_irq_o,
  output logic              host_irq_o
);
  logic           hold_q;
  logic [NCH-1:0] ien_q, ien_nxt;
  logic [NCH-1:0] db_q, db_nxt, st_q, st_nxt;
  logic [NCH-1:0] db_set, db_clr, st_set, st_clr;
  logic           core_live;
  logic [NCH-1:0] host_rd_mux, core_rd_mux;
  logic           core_irq_q, host_irq_q;
  logic [NCH-1:0] host_rdata_q, core_rdata_q;

  // core writes only count once the core is out of reset
  assign core_live = core_we & ~hold_q;

  assign db_set = (host_we   && host_addr == H_DBELL) ? host_wdata : '0;
  assign db_clr = (core_live && core_addr == C_DBELL) ? core_wdata : '0;
  assign st_set = (core_live && core_addr == C_STAT)  ? core_wdata : '0;
  assign st_clr = (host_we   && host_addr == H_STAT)  ? host_wdata : '0;

  hcd_ctrl_reg #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .we_ctrl (host_we && host_addr == H_CTRL),
    .we_ien  (host_we && host_addr == H_IEN),
    .wdata   (host_wdata),
    .hold_q  (hold_q),
    .ien_q   (ien_q),
    .ien_nxt (ien_nxt)
  );

  hcd_event_bits #(.NCH(NCH), .SET_WINS(1'b1)) u_dbell (
    .clk      (clk),
    .rst      (rst),
    .set_i    (db_set),
    .clr_i    (db_clr),
    .bits_q   (db_q),
    .bits_nxt (db_nxt)
  );

  hcd_event_bits #(.NCH(NCH), .SET_WINS(1'b1)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (st_set),
    .clr_i    (st_clr),
    .bits_q   (st_q),
    .bits_nxt (st_nxt)
  );

  always_comb begin
    host_rd_mux = '0;
    unique case (host_addr)
      H_CTRL:  host_rd_mux[0] = ~hold_q;
      H_DBELL: host_rd_mux = db_q;
      H_STAT:  host_rd_mux = st_q;
      default: host_rd_mux = ien_q;
    endcase
  end

  always_comb begin
    core_rd_mux = '0;
    if (core_addr == C_DBELL)     core_rd_mux = db_q;
    else if (core_addr == C_STAT) core_rd_mux = st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_irq_q   <= 1'b0;
      host_irq_q   <= 1'b0;
      host_rdata_q <= '0;
      core_rdata_q <= '0;
    end else begin
      core_irq_q   <= |db_nxt;
      host_irq_q   <= |(st_nxt & ien_nxt);
      host_rdata_q <= host_rd_mux;
      core_rdata_q <= core_rd_mux;
    end
  end

  assign core_rst_o = hold_q;
  assign core_irq_o = core_irq_q;
  assign host_irq_o = host_irq_q;
  assign host_rdata = host_rdata_q;
  assign core_rdata = core_rdata_q;
endmodule

// File: rtl/hcd_doorbell_chk.sv
module hcd_doorbell_chk
  import hcd_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [REG_AW-1:0] host_addr,
  input logic [NCH-1:0]    host_wdata,
  input logic              core_we,
  input logic [REG_AW-1:0] core_addr,
  input logic [NCH-1:0]    core_wdata,
  input logic              core_rst_o,
  input logic              core_irq_o,
  input logic              host_irq_o
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_rst_o && !core_irq_o && !host_irq_o));

  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == H_CTRL) |=> (core_rst_o == !$past(host_wdata[0])));

  // covers R3 and R5: a host set always leaves the core interrupt raised
  p_dbell_raise_r3: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == H_DBELL && |host_wdata) |=> core_irq_o);

  p_dbell_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!core_rst_o && core_we && core_addr == C_DBELL && &core_wdata
     && !(host_we && host_addr == H_DBELL)) |=> !core_irq_o);

  p_held_keeps_dbell_r9: assert property (@(posedge clk) disable iff (rst)
    (core_rst_o && core_irq_o) |=> core_irq_o);

  p_mask_off_r8: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == H_IEN && host_wdata == '0) |=> !host_irq_o);
endmodule

bind hcd_doorbell_top hcd_doorbell_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .core_we    (core_we),
  .core_addr  (core_addr),
  .core_wdata (core_wdata),
  .core_rst_o (core_rst_o),
  .core_irq_o (core_irq_o),
  .host_irq_o (host_irq_o)
);

// File: tb/sim_hcd_doorbell_top.sv
`timescale 1ns/1ps
module sim_hcd_doorbell_top;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           host_we = 1'b0, core_we = 1'b0;
  logic [1:0]     host_addr = '0, core_addr = '0;
  logic [NCH-1:0] host_wdata = '0, core_wdata = '0;
  logic [NCH-1:0] host_rdata, core_rdata;
  logic           core_rst_o, core_irq_o, host_irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  logic           m_hold;
  logic [NCH-1:0] m_ien, m_db, m_st;

  always #4 clk = ~clk;

  hcd_doorbell_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_rst_o(core_rst_o), .core_irq_o(core_irq_o), .host_irq_o(host_irq_o)
  );

  function automatic logic [NCH-1:0] exp_host_rd(logic [1:0] a);
    logic [NCH-1:0] r = '0;
    case (a)
      2'd0: r[0] = ~m_hold;
      2'd1: r = m_db;
      2'd2: r = m_st;
      default: r = m_ien;
    endcase
    return r;
  endfunction

  function automatic logic [NCH-1:0] exp_core_rd(logic [1:0] a);
    // R11: addresses 2 and 3 read zero
    if (a == 2'd0) return m_db;
    if (a == 2'd1) return m_st;
    return '0;
  endfunction

  task automatic chk(string tag, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, compare after the edge
  task automatic step(string tag, logic hw, logic [1:0] ha, logic [NCH-1:0] hd,
                      logic cw, logic [1:0] ca, logic [NCH-1:0] cd);
    logic [NCH-1:0] e_hrd, e_crd, dset, dclr, sset, sclr;
    logic live;
    @(negedge clk);
    host_we = hw; host_addr = ha; host_wdata = hd;
    core_we = cw; core_addr = ca; core_wdata = cd;
    e_hrd = exp_host_rd(ha);                       // R10: pre-edge state
    e_crd = exp_core_rd(ca);
    live  = cw && !m_hold;                         // R9
    dset  = (hw && ha == 2'd1) ? hd : '0;          // R3
    dclr  = (live && ca == 2'd0) ? cd : '0;        // R4
    sset  = (live && ca == 2'd1) ? cd : '0;        // R6
    sclr  = (hw && ha == 2'd2) ? hd : '0;          // R6
    m_db  = dset | (m_db & ~dclr);                 // R5 set wins
    m_st  = sset | (m_st & ~sclr);                 // R7 set wins
    if (hw && ha == 2'd0) m_hold = ~hd[0];         // R2
    if (hw && ha == 2'd3) m_ien = hd;
    @(posedge clk);
    #1;
    chk({tag, "/R2"}, "core_rst_o", NCH'(core_rst_o), NCH'(m_hold));
    chk({tag, "/R4"}, "core_irq_o", NCH'(core_irq_o), NCH'(|m_db));
    chk({tag, "/R8"}, "host_irq_o", NCH'(host_irq_o), NCH'(|(m_st & m_ien)));
    chk({tag, "/R10"}, "host_rdata", host_rdata, e_hrd);
    chk({tag, "/R10"}, "core_rdata", core_rdata, e_crd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_hold = 1'b1; m_ien = '0; m_db = '0; m_st = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk("R1", "core_rst_o", NCH'(core_rst_o), NCH'(1));
    chk("R1", "core_irq_o", NCH'(core_irq_o), '0);
    chk("R1", "host_irq_o", NCH'(host_irq_o), '0);
    chk("R1", "host_rdata", host_rdata, '0);
    for (int a = 0; a < 4; a++) step("R1", 1'b0, 2'(a), '0, 1'b0, 2'(a), '0);

    // R3: doorbell while held; R9: core writes ignored while held
    step("R3", 1'b1, 2'd1, 8'h05, 1'b0, 2'd0, '0);
    step("R9", 1'b0, 2'd1, '0, 1'b1, 2'd0, 8'hFF);
    step("R9", 1'b0, 2'd2, '0, 1'b1, 2'd1, 8'hFF);
    step("R9", 1'b0, 2'd2, '0, 1'b0, 2'd0, '0);
    // R2: release
    step("R2", 1'b1, 2'd0, 8'h01, 1'b0, 2'd0, '0);
    step("R2", 1'b0, 2'd0, '0, 1'b0, 2'd0, '0);
    // R5: host sets and core clears the same bit
    step("R5", 1'b1, 2'd1, 8'h01, 1'b1, 2'd0, 8'h05);
    step("R5", 1'b0, 2'd1, '0, 1'b0, 2'd0, '0);
    step("R4", 1'b0, 2'd1, '0, 1'b1, 2'd0, 8'h01);
    // R8: mask off then on
    step("R8", 1'b0, 2'd2, '0, 1'b1, 2'd1, 8'h30);
    step("R8", 1'b1, 2'd3, 8'h10, 1'b0, 2'd1, '0);
    // R7: collision on status
    step("R7", 1'b1, 2'd2, 8'h30, 1'b1, 2'd1, 8'h10);
    step("R6", 1'b1, 2'd2, 8'h10, 1'b0, 2'd1, '0);
    step("R6", 1'b0, 2'd2, '0, 1'b0, 2'd1, '0);
    // R11: unused core addresses
    step("R11", 1'b0, 2'd1, '0, 1'b1, 2'd2, 8'hFF);
    step("R11", 1'b0, 2'd2, '0, 1'b1, 2'd3, 8'hFF);
    // R2: hold again, then R9 under hold
    step("R2", 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, '0);
    step("R9", 1'b1, 2'd1, 8'h80, 1'b1, 2'd0, 8'hFF);
    step("R9", 1'b0, 2'd1, '0, 1'b0, 2'd0, '0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic hw, cw;
      logic [1:0] ha, ca;
      hw = ($urandom_range(0, 3) != 0);
      cw = ($urandom_range(0, 2) != 0);
      ha = 2'($urandom_range(0, 3));
      ca = 2'($urandom_range(0, 3));
      // keep the core released most of the time
      if (hw && ha == 2'd0 && $urandom_range(0, 3) != 0)
        step("RND", hw, ha, 8'h01, cw, ca, NCH'($urandom));
      else
        step("RND", hw, ha, NCH'($urandom), cw, ca, NCH'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule